// File: doc/BRIEF.md
# Three-Port Programmable Parallel Interface

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a small synchronous register bus. The bus has an active-low chip select, two address bits, active-low read and write strobes, an 8-bit write bus and an 8-bit read bus. The two address bits pick port A, port B, port C or the control register. Each port pin has an input, an output value and an output enable. The pad ring does the tri-stating, so a released pin is simply one whose enable is low.

A single control register holds the configuration. If the top bit of a control write is set, the byte reprograms the port modes and directions. If the top bit is clear, the byte sets or clears one bit of the port C latch and leaves the configuration alone. The ports are split into two groups. Group A is port A plus the upper half of port C. Group B is port B plus the lower half of port C.

There are three modes. In simple mode a port is a plain latch or a plain input. In strobed mode, port A or port B transfers data under a strobe or acknowledge handshake. In bidirectional mode, port A carries data in both directions. In the two handshake modes, fixed port C lines carry the handshake inputs, the buffer-full flags and the interrupt requests. The interrupt enables are bits of the port C latch.

Top module: `tri_port_pio`

## Requirements
- R1: After reset, every port is in simple mode with all pins released (all enables 0), and every output latch is 0.
- R2: A bus cycle with cs_n low and wr_n or rd_n low selects a target by addr: 0 is port A, 1 is port B, 2 is port C, 3 is control. A write that happens while cs_n is high changes nothing.
- R3: A control write with bit 7 = 1 is a mode word. Its fields are:
  - bits 6:5: group A mode (00 simple, 01 strobed, 1x bidirectional)
  - bit 4: port A is input
  - bit 3: upper port C is input
  - bit 2: group B mode (1 = strobed)
  - bit 1: port B is input
  - bit 0: lower port C is input
- R4: A mode word clears the port A, B and C output latches and all handshake flags to 0 in the next cycle.
- R5: A control write with bit 7 = 0 writes the value of bit 0 into the port C latch bit chosen by bits 3:1. The mode, the directions and the other latches do not change.
- R6: In simple mode, an output port drives its latch and a read returns the latch. An input port is never driven, and a read returns the live pins.
- R7: In strobed input on port A, PC4 is the active-low strobe and PC5 is the buffer-full flag. On port B these are PC2 and PC1. The strobe's falling edge captures the port into a holding register and sets buffer-full. A read of the port returns the captured byte and clears buffer-full.
- R8: A strobed-input interrupt request (PC3 for port A, PC0 for port B) is buffer-full AND the enable bit. The enable is latch bit PC4 for A and PC2 for B.
- R9: In strobed output, a port write drives the new byte and pulls the active-low full flag low (PC7 for A, PC1 for B). The active-low acknowledge (PC6 for A, PC2 for B) going low releases the flag. Its rising edge raises the interrupt request (PC3 for A, PC0 for B) if the enable bit (PC6 for A, PC2 for B) is set. The next port write clears the request.
- R10: In bidirectional mode, port A is driven only while PC6 is low. A falling edge on PC4 captures input into the holding register, which a port A read returns. Group B keeps its own mode.
- R11: Port C lines not used for handshake follow the direction of their half. A port C read returns each driven line's output value and each undriven line's pin. On a handshake input line, the read returns that line's enable latch bit instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Register select |
| wr_n | input | 1 | Active-low write strobe, one write per cycle held low |
| rd_n | input | 1 | Active-low read strobe, read side effects at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is in progress |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values, handshake flags included |
| pc_oe | output | 8 | Port C output enables |

## Verification
A wrong configuration register shows at the output enables in the cycle after the control write. It also shows as a pin driven against an input, or as a handshake line left driven. A stuck or missed buffer-full or output-full flag shows on its port C line one cycle after the strobe, acknowledge, read or write that should have changed it. The interrupt request lines then disagree with the enable bits on the same edge. A set/reset command that hits the wrong bit, or one that disturbs the mode, shows on the port C pins and the port enables at once, with no delay beyond the write cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int PW = 8;

  typedef enum logic [1:0] {
    PM_SIMPLE   = 2'd0,
    PM_STROBED  = 2'd1,
    PM_BIDIR    = 2'd2
  } pmode_e;

  typedef struct packed {
    pmode_e a_mode;
    logic   a_in;
    logic   cu_in;
    logic   b_strobed;
    logic   b_in;
    logic   cl_in;
  } pio_cfg_t;

  // handshake line positions on port C
  localparam int HS_INTR_B = 0;
  localparam int HS_FLAG_B = 1;
  localparam int HS_STB_B  = 2;
  localparam int HS_INTR_A = 3;
  localparam int HS_STB_A  = 4;
  localparam int HS_IBF_A  = 5;
  localparam int HS_ACK_A  = 6;
  localparam int HS_OBF_A  = 7;

  localparam pio_cfg_t CFG_RESET = '{a_mode: PM_SIMPLE, a_in: 1'b1, cu_in: 1'b1,
                                     b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pio_cfg_t decode_mode(input logic [6:0] w);
    pio_cfg_t c;
    if (w[6])      c.a_mode = PM_BIDIR;
    else if (w[5]) c.a_mode = PM_STROBED;
    else           c.a_mode = PM_SIMPLE;
    c.a_in      = w[4];
    c.cu_in     = w[3];
    c.b_strobed = w[2];
    c.b_in      = w[1];
    c.cl_in     = w[0];
    return c;
  endfunction

endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
#(
  parameter int W = PW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic         pc_we,
  input  logic [W-1:0] wdata,
  output pio_cfg_t     cfg,
  output logic [W-1:0] pc_lat,
  output logic         mode_wr,
  output logic         bsr_wr
);
  localparam int IW = $clog2(W);

  assign mode_wr = ctl_we &  wdata[W-1];
  assign bsr_wr  = ctl_we & ~wdata[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      pc_lat <= '0;
    end else if (mode_wr) begin
      cfg    <= decode_mode(wdata[6:0]);
      pc_lat <= '0;
    end else if (bsr_wr) begin
      pc_lat[wdata[IW:1]] <= wdata[0];
    end else if (pc_we) begin
      pc_lat <= wdata;
    end
  end

endmodule

// File: rtl/pio_hs_chan.sv
module pio_hs_chan
  import pio_pkg::*;
#(
  parameter int W     = PW,
  parameter int BIDIR = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  pmode_e       mode,
  input  logic         dir_in,
  input  logic         wr_port,
  input  logic         rd_port,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins_in,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic         inte_in,
  input  logic         inte_out,
  output logic [W-1:0] pins_out,
  output logic [W-1:0] pins_oe,
  output logic [W-1:0] rd_val,
  output logic         ibf,
  output logic         obf_n,
  output logic         intr,
  output logic         stb_fall,
  output logic         ack_rise
);
  logic [W-1:0] out_lat, in_lat;
  logic ibf_q, obf_q, done_q, stb_q, ack_q;
  logic bidir_on, can_rx, can_tx;

  assign bidir_on = (BIDIR != 0) && (mode == PM_BIDIR);
  assign can_rx   = ((mode == PM_STROBED) &&  dir_in) || bidir_on;
  assign can_tx   = ((mode == PM_STROBED) && !dir_in) || bidir_on;
  assign stb_fall = stb_q & ~stb_n & can_rx;
  assign ack_rise = ~ack_q & ack_n & can_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lat <= '0;
      in_lat  <= '0;
      ibf_q   <= 1'b0;
      obf_q   <= 1'b0;
      done_q  <= 1'b0;
      stb_q   <= 1'b1;
      ack_q   <= 1'b1;
    end else begin
      stb_q <= stb_n;
      ack_q <= ack_n;
      if (clr) begin
        out_lat <= '0;
        in_lat  <= '0;
        ibf_q   <= 1'b0;
        obf_q   <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (wr_port) begin
          out_lat <= wdata;
          obf_q   <= can_tx;
          done_q  <= 1'b0;
        end else begin
          if (!ack_n && can_tx) obf_q <= 1'b0;
          if (ack_rise) done_q <= 1'b1;
        end
        if (stb_fall) begin
          in_lat <= pins_in;
          ibf_q  <= 1'b1;
        end else if (rd_port && can_rx) begin
          ibf_q <= 1'b0;
        end
      end
    end
  end

  assign pins_out = out_lat;
  assign ibf      = ibf_q;
  assign obf_n    = ~obf_q;
  assign intr     = (ibf_q & inte_in & can_rx) | (done_q & inte_out & can_tx);

  always_comb begin
    case (mode)
      PM_SIMPLE:  rd_val = dir_in ? pins_in : out_lat;
      PM_STROBED: rd_val = dir_in ? in_lat  : out_lat;
      default:    rd_val = in_lat;
    endcase
  end

  if (BIDIR != 0) begin : g_bidir
    assign pins_oe = (mode == PM_BIDIR) ? {W{~ack_n}} : {W{~dir_in}};
  end else begin : g_uni
    assign pins_oe = {W{~dir_in}};
  end

endmodule

// File: rtl/pio_pc_route.sv
module pio_pc_route
  import pio_pkg::*;
#(
  parameter int W = PW
) (
  input  pio_cfg_t     cfg,
  input  logic [W-1:0] pc_lat,
  input  logic [W-1:0] pc_in,
  input  logic         a_ibf,
  input  logic         a_obf_n,
  input  logic         a_intr,
  input  logic         b_ibf,
  input  logic         b_obf_n,
  input  logic         b_intr,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe,
  output logic [W-1:0] pc_rd,
  output logic         a_stb_n,
  output logic         a_ack_n,
  output logic         b_hs_n,
  output logic         a_inte_in,
  output logic         a_inte_out,
  output logic         b_inte
);
  localparam int HALF = W / 2;
  logic [W-1:0] hs_in;

  assign a_stb_n    = pc_in[HS_STB_A];
  assign a_ack_n    = pc_in[HS_ACK_A];
  assign b_hs_n     = pc_in[HS_STB_B];
  assign a_inte_in  = pc_lat[HS_STB_A];
  assign a_inte_out = pc_lat[HS_ACK_A];
  assign b_inte     = pc_lat[HS_STB_B];

  always_comb begin
    hs_in = '0;
    for (int i = 0; i < W; i++) begin
      pc_out[i] = pc_lat[i];
      pc_oe[i]  = (i < HALF) ? ~cfg.cl_in : ~cfg.cu_in;
    end
    if (cfg.b_strobed) begin
      pc_oe[HS_STB_B]   = 1'b0;
      hs_in[HS_STB_B]   = 1'b1;
      pc_out[HS_FLAG_B] = cfg.b_in ? b_ibf : b_obf_n;
      pc_oe[HS_FLAG_B]  = 1'b1;
      pc_out[HS_INTR_B] = b_intr;
      pc_oe[HS_INTR_B]  = 1'b1;
    end
    if (cfg.a_mode != PM_SIMPLE) begin
      pc_out[HS_INTR_A] = a_intr;
      pc_oe[HS_INTR_A]  = 1'b1;
      if (cfg.a_mode == PM_BIDIR || cfg.a_in) begin
        pc_oe[HS_STB_A]  = 1'b0;
        hs_in[HS_STB_A]  = 1'b1;
        pc_out[HS_IBF_A] = a_ibf;
        pc_oe[HS_IBF_A]  = 1'b1;
      end
      if (cfg.a_mode == PM_BIDIR || !cfg.a_in) begin
        pc_oe[HS_ACK_A]  = 1'b0;
        hs_in[HS_ACK_A]  = 1'b1;
        pc_out[HS_OBF_A] = a_obf_n;
        pc_oe[HS_OBF_A]  = 1'b1;
      end
    end
    for (int i = 0; i < W; i++) begin
      if (hs_in[i])     pc_rd[i] = pc_lat[i];
      else if (pc_oe[i]) pc_rd[i] = pc_out[i];
      else              pc_rd[i] = pc_in[i];
    end
  end

endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
#(
  parameter int W = PW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic [1:0]   addr,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  logic wr_stb, rd_stb;
  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  pio_cfg_t cfg;
  pmode_e b_mode;
  logic [W-1:0] pc_lat, a_rd, b_rd, pc_rd;
  logic mode_wr, bsr_wr;
  logic a_ibf, a_obf_n, a_intr, a_stb_fall, a_ack_rise;
  logic b_ibf, b_obf_n, b_intr, b_stb_fall, b_ack_rise;
  logic a_stb_n, a_ack_n, b_hs_n, a_inte_in, a_inte_out, b_inte;

  assign wr_stb = ~cs_n & ~wr_n;
  assign rd_stb = ~cs_n & ~rd_n;
  assign wr_a   = wr_stb && addr == 2'd0;
  assign wr_b   = wr_stb && addr == 2'd1;
  assign wr_c   = wr_stb && addr == 2'd2;
  assign wr_ctl = wr_stb && addr == 2'd3;
  assign rd_a   = rd_stb && addr == 2'd0;
  assign rd_b   = rd_stb && addr == 2'd1;
  assign b_mode = cfg.b_strobed ? PM_STROBED : PM_SIMPLE;

  pio_ctrl_reg #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(wr_ctl), .pc_we(wr_c), .wdata(wdata),
    .cfg(cfg), .pc_lat(pc_lat), .mode_wr(mode_wr), .bsr_wr(bsr_wr)
  );

  pio_hs_chan #(.W(W), .BIDIR(1)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .mode(cfg.a_mode), .dir_in(cfg.a_in),
    .wr_port(wr_a), .rd_port(rd_a), .wdata(wdata), .pins_in(pa_in),
    .stb_n(a_stb_n), .ack_n(a_ack_n), .inte_in(a_inte_in), .inte_out(a_inte_out),
    .pins_out(pa_out), .pins_oe(pa_oe), .rd_val(a_rd), .ibf(a_ibf), .obf_n(a_obf_n),
    .intr(a_intr), .stb_fall(a_stb_fall), .ack_rise(a_ack_rise)
  );

  pio_hs_chan #(.W(W), .BIDIR(0)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .mode(b_mode), .dir_in(cfg.b_in),
    .wr_port(wr_b), .rd_port(rd_b), .wdata(wdata), .pins_in(pb_in),
    .stb_n(b_hs_n), .ack_n(b_hs_n), .inte_in(b_inte), .inte_out(b_inte),
    .pins_out(pb_out), .pins_oe(pb_oe), .rd_val(b_rd), .ibf(b_ibf), .obf_n(b_obf_n),
    .intr(b_intr), .stb_fall(b_stb_fall), .ack_rise(b_ack_rise)
  );

  pio_pc_route #(.W(W)) u_route (
    .cfg(cfg), .pc_lat(pc_lat), .pc_in(pc_in),
    .a_ibf(a_ibf), .a_obf_n(a_obf_n), .a_intr(a_intr),
    .b_ibf(b_ibf), .b_obf_n(b_obf_n), .b_intr(b_intr),
    .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd),
    .a_stb_n(a_stb_n), .a_ack_n(a_ack_n), .b_hs_n(b_hs_n),
    .a_inte_in(a_inte_in), .a_inte_out(a_inte_out), .b_inte(b_inte)
  );

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      case (addr)
        2'd0:    rdata = a_rd;
        2'd1:    rdata = b_rd;
        2'd2:    rdata = pc_rd;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pio_chk.sv
module pio_chk
  import pio_pkg::*;
#(
  parameter int W = PW
) (
  input logic         clk,
  input logic         rst_n,
  input pio_cfg_t     cfg,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pc_lat,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] pc_out,
  input logic         mode_wr,
  input logic         bsr_wr,
  input logic         rd_a,
  input logic         a_ibf,
  input logic         a_stb_fall
);
  // R4
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_out == '0 && pb_out == '0 && pc_lat == '0));

  // R5
  bsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $stable(cfg));

  // R5
  bsr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> pc_lat[$past(wdata[3:1])] == $past(wdata[0]));

  // R6
  input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_mode == PM_SIMPLE && cfg.a_in) |-> pa_oe == '0);

  // R7
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_stb_fall |=> a_ibf);

  // R7
  ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && a_ibf && !a_stb_fall && !mode_wr) |=> !a_ibf);

  // R8
  intr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_mode == PM_STROBED && cfg.a_in) |-> pc_out[HS_INTR_A] == (a_ibf && pc_lat[HS_STB_A]));

  // R10
  bidir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_mode == PM_BIDIR) |-> pa_oe == {W{~pc_in[HS_ACK_A]}});

endmodule

bind tri_port_pio pio_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .wdata(wdata), .pc_lat(pc_lat),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pc_in(pc_in), .pc_out(pc_out),
  .mode_wr(mode_wr), .bsr_wr(bsr_wr), .rd_a(rd_a), .a_ibf(a_ibf), .a_stb_fall(a_stb_fall)
);

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  int vectors = 0;
  int errs = 0;

  always #10 clk = ~clk;

  tri_port_pio u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_n(wr_n), .rd_n(rd_n),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
  endtask

  task automatic t_simple_out();
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    chk("R3 pa_oe", pa_oe, 8'hFF);
    chk("R3 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    chk("R6 pa_out", pa_out, 8'h5A);
    chk("R2 pb_out", pb_out, 8'hC3);
    chk("R2 pc_out", pc_out, 8'h96);
    bus_rd(2'd0, d);
    chk("R6 read latch", d, 8'h5A);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'h00;
    @(negedge clk);
    wr_n = 1'b1;
    chk("R2 deselected write", pa_out, 8'h5A);
    bus_wr(2'd3, 8'h80);
    chk("R4 clear A", pa_out, 8'h00);
    chk("R4 clear B", pb_out, 8'h00);
    chk("R4 clear C", pc_out, 8'h00);
  endtask

  task automatic t_bitset();
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd3, 8'h0F);
    chk("R5 set bit7", pc_out, 8'h80);
    bus_wr(2'd3, 8'h05);
    chk("R5 set bit2", pc_out, 8'h84);
    bus_wr(2'd3, 8'h0E);
    chk("R5 clear bit7", pc_out, 8'h04);
    chk("R5 port A kept", pa_out, 8'h11);
    chk("R5 mode kept", pa_oe, 8'hFF);
  endtask

  task automatic t_simple_in();
    logic [7:0] d;
    bus_wr(2'd3, 8'h9B);
    chk("R6 A released", pa_oe, 8'h00);
    chk("R6 C released", pc_oe, 8'h00);
    pa_in = 8'h3C; pb_in = 8'h81;
    bus_rd(2'd0, d);
    chk("R6 read A pins", d, 8'h3C);
    bus_rd(2'd1, d);
    chk("R6 read B pins", d, 8'h81);
    bus_wr(2'd3, 8'h88);
    chk("R11 split C", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'h06);
    pc_in = 8'hA5;
    bus_rd(2'd2, d);
    chk("R11 read C mixed", d, 8'hA6);
    pc_in = 8'hFF;
  endtask

  task automatic t_strobe_in();
    logic [7:0] d;
    bus_wr(2'd3, 8'hB0);
    chk("R7 C enables", pc_oe, 8'hEF);
    chk("R7 ibf idle", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h77;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk);
    chk("R7 ibf set", {7'd0, pc_out[5]}, 8'h01);
    chk("R8 intr set", {7'd0, pc_out[3]}, 8'h01);
    pc_in[4] = 1'b1; pa_in = 8'h00;
    bus_rd(2'd2, d);
    chk("R11 read C status", d, 8'h38);
    bus_rd(2'd0, d);
    chk("R7 captured byte", d, 8'h77);
    chk("R7 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
    chk("R8 intr cleared", {7'd0, pc_out[3]}, 8'h00);
    bus_wr(2'd3, 8'h08);
    pa_in = 8'h55;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk);
    pc_in[4] = 1'b1;
    chk("R7 ibf no inte", {7'd0, pc_out[5]}, 8'h01);
    chk("R8 intr masked", {7'd0, pc_out[3]}, 8'h00);
    bus_rd(2'd0, d);
    chk("R7 second byte", d, 8'h55);
  endtask

  task automatic t_strobe_out_b();
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    chk("R9 obf idle", {7'd0, pc_out[1]}, 8'h01);
    bus_wr(2'd1, 8'hE1);
    chk("R9 data", pb_out, 8'hE1);
    chk("R9 obf low", {7'd0, pc_out[1]}, 8'h00);
    chk("R9 intr idle", {7'd0, pc_out[0]}, 8'h00);
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk);
    chk("R9 obf released", {7'd0, pc_out[1]}, 8'h01);
    chk("R9 intr wait", {7'd0, pc_out[0]}, 8'h00);
    pc_in[2] = 1'b1;
    @(negedge clk);
    chk("R9 intr raised", {7'd0, pc_out[0]}, 8'h01);
    bus_wr(2'd1, 8'h22);
    chk("R9 intr cleared", {7'd0, pc_out[0]}, 8'h00);
    chk("R9 obf again", {7'd0, pc_out[1]}, 8'h00);
  endtask

  task automatic t_bidir();
    logic [7:0] d;
    bus_wr(2'd3, 8'hC0);
    chk("R10 A idle", pa_oe, 8'h00);
    chk("R10 B unaffected", pb_oe, 8'hFF);
    bus_wr(2'd0, 8'h3D);
    chk("R10 obf low", {7'd0, pc_out[7]}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    #1;
    chk("R10 drive on ack", pa_oe, 8'hFF);
    chk("R10 drive data", pa_out, 8'h3D);
    @(negedge clk);
    chk("R10 obf released", {7'd0, pc_out[7]}, 8'h01);
    pc_in[6] = 1'b1;
    #1;
    chk("R10 release", pa_oe, 8'h00);
    pa_in = 8'h42;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk);
    pc_in[4] = 1'b1;
    chk("R10 ibf", {7'd0, pc_out[5]}, 8'h01);
    bus_rd(2'd0, d);
    chk("R10 input byte", d, 8'h42);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_simple_out();
    t_bitset();
    t_simple_in();
    t_strobe_in();
    t_strobe_out_b();
    t_bidir();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule